// File: doc/BRIEF.md
# Keyed Index/Data PCI Interrupt Steering Unit

This block routes four active-low PCI interrupt inputs onto a sixteen-line ISA IRQ bus. Software configures it through two I/O ports. An index port selects one internal register, and a data port reads or writes the register selected. A key register guards the register file. After reset the block is locked. Writing the unlock key opens the register file, and writing any other value to the key register locks it again.

Two routing bytes each hold two 4-bit codes, one code per interrupt input. The codes use a non-linear table, so the code value does not equal the IRQ number. A sensitivity byte selects, for each input, one of two forwarding modes:
- Level mode passes the synchronised, inverted input level.
- Edge mode turns each assertion into a single-clock pulse.

Inputs routed to the same IRQ are ORed together.

Top module: `irq_steer_unit`

## Requirements
- R1: A write to I/O address 0x22 loads the index register. A read of address 0x22 returns the index. A read of address 0x23 returns the register the index selects. Read data appears on `io_rdata` from the clock edge that samples `io_rd`. A read of any other address returns 0xFF.
- R2: The key register is at index 0x03. Writing 0xC5 to it unlocks the register file. Writing any other value locks it. Reading it returns 0x01 when unlocked and 0x00 when locked.
- R3: While the block is locked, data-port writes to any index other than 0x03 leave every register unchanged.
- R4: Index 0x42 holds the code for input 1 in bits 3:0 and the code for input 2 in bits 7:4. Index 0x43 holds input 3 in bits 3:0 and input 4 in bits 7:4. The codes map as follows: 1→IRQ9, 2→IRQ3, 3→IRQ10, 4→IRQ4, 5→IRQ5, 6→IRQ7, 7→IRQ6, 9→IRQ11, 11→IRQ12, 13→IRQ14, 15→IRQ15.
- R5: Code 0 (disabled) and the reserved codes 8, 10, 12 and 14 drive no IRQ line. IRQ lines 0, 1, 2, 8 and 13 are never driven.
- R6: Index 0x44 bit k selects the mode for input k+1. A value of 1 selects edge mode: each high-to-low transition of the input gives exactly one clock of high on the mapped IRQ, even while the input stays low. Bits 7:4 read as 0.
- R7: In level mode (bit = 0), the mapped IRQ equals the inverted input, delayed by the two-flop synchroniser. A change applied before clock edge n is visible after edge n+1.
- R8: While the block is locked, reads of any index other than 0x03 return 0xFF. While it is unlocked, undefined indices read 0x00 and writes to them change nothing.
- R9: When several inputs map to the same IRQ, that IRQ is the OR of their individual contributions. This holds even when one input is in edge mode and another is in level mode.
- R10: After reset:
  - the block is locked;
  - 0x42, 0x43 and 0x44 read 0x00;
  - the index is 0x00;
  - all IRQ outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| intx_n | input | 4 | Active-low PCI interrupt inputs, bit 0 = input 1 |
| isa_irq | output | 16 | Active-high ISA IRQ lines |

## Verification
Two functions can fall in the same cycle: an edge-mode pulse and a level-mode assertion on a shared IRQ. The bench maps inputs 1 and 2 to IRQ9, puts input 1 in edge mode and input 2 in level mode, and asserts both inputs on the same clock. It judges the result by checking the following:
- IRQ9 rises two edges later.
- IRQ9 stays high when the pulse ends, because the level input holds it.
- IRQ9 falls two edges after input 2 is released.

A second collision puts a locked data-port write against the routing register, then checks that the live routing is undisturbed.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

   localparam int ISA_IRQS = 16;

   // Non-linear code table: returns a one-hot IRQ vector, zero for disabled/reserved
   function automatic logic [ISA_IRQS-1:0] code_to_irq(input logic [3:0] code);
      logic [ISA_IRQS-1:0] v;
      v = '0;
      case (code)
         4'd1:    v[9]  = 1'b1;
         4'd2:    v[3]  = 1'b1;
         4'd3:    v[10] = 1'b1;
         4'd4:    v[4]  = 1'b1;
         4'd5:    v[5]  = 1'b1;
         4'd6:    v[7]  = 1'b1;
         4'd7:    v[6]  = 1'b1;
         4'd9:    v[11] = 1'b1;
         4'd11:   v[12] = 1'b1;
         4'd13:   v[14] = 1'b1;
         4'd15:   v[15] = 1'b1;
         default: v = '0;
      endcase
      return v;
   endfunction

   localparam logic [ISA_IRQS-1:0] REACHABLE_IRQS = 16'b1101_1110_1111_1000;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int          ADDR_W     = 16,
   parameter int          NUM_LINES  = 4,
   parameter logic [15:0] IDX_PORT   = 16'h0022,
   parameter logic [15:0] DATA_PORT  = 16'h0023,
   parameter logic [7:0]  KEY_IDX    = 8'h03,
   parameter logic [7:0]  MAP_BASE   = 8'h42,
   parameter logic [7:0]  SENS_IDX   = 8'h44,
   parameter logic [7:0]  OPEN_KEY   = 8'hC5,
   localparam int         MAP_REGS   = (NUM_LINES + 1) / 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       io_addr,
   input  logic                    io_wr,
   input  logic                    io_rd,
   input  logic [7:0]              io_wdata,
   output logic [7:0]              io_rdata,
   output logic [8*MAP_REGS-1:0]   route_codes,
   output logic [NUM_LINES-1:0]    edge_sel
);

   if (NUM_LINES < 1 || NUM_LINES > 8) begin : g_bad_lines
      $error("irq_cfg_regs: NUM_LINES must be 1..8");
   end
   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr
      $error("irq_cfg_regs: ADDR_W must be 8..16");
   end

   logic [7:0]                 idx_q;
   logic                       open_q;
   logic [MAP_REGS-1:0][7:0]   map_q;
   logic [NUM_LINES-1:0]       sens_q;
   logic [7:0]                 rd_next;
   logic                       hit_idx, hit_data;

   assign hit_idx  = (io_addr == IDX_PORT[ADDR_W-1:0]);
   assign hit_data = (io_addr == DATA_PORT[ADDR_W-1:0]);

   always_comb begin
      rd_next = 8'hFF;
      if (hit_idx) begin
         rd_next = idx_q;
      end else if (hit_data) begin
         if (idx_q == KEY_IDX) begin
            rd_next = {7'd0, open_q};
         end else if (open_q) begin
            rd_next = 8'h00;
            for (int k = 0; k < MAP_REGS; k++) begin
               if (idx_q == 8'(MAP_BASE + k)) rd_next = map_q[k];
            end
            if (idx_q == SENS_IDX) rd_next = 8'(sens_q);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q    <= 8'h00;
         open_q   <= 1'b0;
         map_q    <= '0;
         sens_q   <= '0;
         io_rdata <= 8'h00;
      end else begin
         if (io_wr && hit_idx) idx_q <= io_wdata;
         if (io_wr && hit_data) begin
            if (idx_q == KEY_IDX) begin
               open_q <= (io_wdata == OPEN_KEY);
            end else if (open_q) begin
               for (int k = 0; k < MAP_REGS; k++) begin
                  if (idx_q == 8'(MAP_BASE + k)) map_q[k] <= io_wdata;
               end
               if (idx_q == SENS_IDX) sens_q <= io_wdata[NUM_LINES-1:0];
            end
         end
         if (io_rd) io_rdata <= rd_next;
      end
   end

   assign route_codes = map_q;
   assign edge_sel    = sens_q;

   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit_data && !open_q && idx_q != KEY_IDX) |=> ($stable(map_q) && $stable(sens_q))); // R3

   AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit_data && idx_q == KEY_IDX && io_wdata == OPEN_KEY) |=> open_q); // R2

   AST_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit_data && idx_q == KEY_IDX && io_wdata != OPEN_KEY) |=> !open_q); // R2

   AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && hit_data && !open_q && idx_q != KEY_IDX) |=> (io_rdata == 8'hFF)); // R8

endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic intx_n,
   input  logic edge_mode,
   output logic active
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_line_cond: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   lvl, pulse;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], intx_n};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign lvl    = ~sync_q[SYNC_STAGES-1];
   assign pulse  = prev_q & ~sync_q[SYNC_STAGES-1];
   assign active = edge_mode ? pulse : lvl;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && active) |=> !(pulse)); // R6

endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux
   import irq_steer_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int IRQ_LINES = 16
) (
   input  logic [NUM_LINES-1:0]   line_active,
   input  logic [4*NUM_LINES-1:0] line_code,
   output logic [IRQ_LINES-1:0]   irq_out
);

   if (IRQ_LINES != ISA_IRQS) begin : g_bad_irqs
      $error("irq_route_mux: IRQ_LINES must equal the code table width");
   end

   logic [NUM_LINES-1:0][IRQ_LINES-1:0] contrib;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign contrib[i] = line_active[i] ? code_to_irq(line_code[4*i +: 4]) : '0;
   end

   always_comb begin
      irq_out = '0;
      for (int i = 0; i < NUM_LINES; i++) irq_out = irq_out | contrib[i];
   end

endmodule

// File: rtl/irq_steer_unit.sv
module irq_steer_unit
   import irq_steer_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter int          NUM_LINES   = 4,
   parameter int          IRQ_LINES   = 16,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] IDX_PORT    = 16'h0022,
   parameter logic [15:0] DATA_PORT   = 16'h0023,
   parameter logic [7:0]  KEY_IDX     = 8'h03,
   parameter logic [7:0]  MAP_BASE    = 8'h42,
   parameter logic [7:0]  SENS_IDX    = 8'h44,
   parameter logic [7:0]  OPEN_KEY    = 8'hC5,
   localparam int         MAP_REGS    = (NUM_LINES + 1) / 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic                  io_wr,
   input  logic                  io_rd,
   input  logic [7:0]            io_wdata,
   output logic [7:0]            io_rdata,
   input  logic [NUM_LINES-1:0]  intx_n,
   output logic [IRQ_LINES-1:0]  isa_irq
);

   logic [8*MAP_REGS-1:0] route_codes;
   logic [NUM_LINES-1:0]  edge_sel;
   logic [NUM_LINES-1:0]  line_active;

   irq_cfg_regs #(
      .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .IDX_PORT(IDX_PORT),
      .DATA_PORT(DATA_PORT), .KEY_IDX(KEY_IDX), .MAP_BASE(MAP_BASE),
      .SENS_IDX(SENS_IDX), .OPEN_KEY(OPEN_KEY)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .route_codes(route_codes), .edge_sel(edge_sel)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_cond
      irq_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
         .clk(clk), .rst_n(rst_n), .intx_n(intx_n[i]),
         .edge_mode(edge_sel[i]), .active(line_active[i])
      );
   end

   irq_route_mux #(.NUM_LINES(NUM_LINES), .IRQ_LINES(IRQ_LINES)) u_mux (
      .line_active(line_active),
      .line_code(route_codes[4*NUM_LINES-1:0]),
      .irq_out(isa_irq)
   );

   AST_NO_STRAY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((isa_irq & ~REACHABLE_IRQS) == '0)); // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((&intx_n) && $past(&intx_n) && $past(&intx_n, 2) && !$rose(rst_n) && !$past($rose(rst_n))) |-> (isa_irq == '0)); // R10

endmodule

// File: tb/irq_steer_unit_test.sv
module irq_steer_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h0;
   logic [7:0]  io_rdata;
   logic [3:0]  intx_n = 4'hF;
   logic [15:0] isa_irq;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   irq_steer_unit uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .intx_n(intx_n), .isa_irq(isa_irq)
   );

   function automatic logic [15:0] exp_irq(input logic [3:0] code);
      case (code)
         4'd1:  return 16'h0001 << 9;
         4'd2:  return 16'h0001 << 3;
         4'd3:  return 16'h0001 << 10;
         4'd4:  return 16'h0001 << 4;
         4'd5:  return 16'h0001 << 5;
         4'd6:  return 16'h0001 << 7;
         4'd7:  return 16'h0001 << 6;
         4'd9:  return 16'h0001 << 11;
         4'd11: return 16'h0001 << 12;
         4'd13: return 16'h0001 << 14;
         4'd15: return 16'h0001 << 15;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      d = io_rdata;
   endtask

   task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
      io_write(16'h0022, idx);
      io_write(16'h0023, d);
   endtask

   task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
      io_write(16'h0022, idx);
      io_read(16'h0023, d);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R10 irq idle", 32'(isa_irq), 32'h0);
      io_read(16'h0022, d);  chk("R10 index", 32'(d), 32'h00);
      reg_read(8'h03, d);    chk("R10 locked", 32'(d), 32'h00);
      reg_read(8'h42, d);    chk("R8 locked read", 32'(d), 32'hFF);
      reg_write(8'h03, 8'hC5);
      reg_read(8'h42, d);    chk("R10 map0", 32'(d), 32'h00);
      reg_read(8'h43, d);    chk("R10 map1", 32'(d), 32'h00);
      reg_read(8'h44, d);    chk("R10 sens", 32'(d), 32'h00);
      reg_write(8'h03, 8'h00);
   endtask

   task automatic t_access();
      logic [7:0] d;
      io_write(16'h0022, 8'h5A);
      io_read(16'h0022, d);  chk("R1 index readback", 32'(d), 32'h5A);
      io_read(16'h0040, d);  chk("R1 other address", 32'(d), 32'hFF);
   endtask

   task automatic t_lock();
      logic [7:0] d;
      reg_write(8'h42, 8'h11);
      reg_write(8'h44, 8'h0F);
      reg_write(8'h03, 8'hC5);
      reg_read(8'h03, d);    chk("R2 unlocked", 32'(d), 32'h01);
      reg_read(8'h42, d);    chk("R3 map unchanged", 32'(d), 32'h00);
      reg_read(8'h44, d);    chk("R3 sens unchanged", 32'(d), 32'h00);
      reg_write(8'h03, 8'hC4);
      reg_read(8'h03, d);    chk("R2 relocked", 32'(d), 32'h00);
      reg_write(8'h03, 8'hC5);
      reg_write(8'h50, 8'hAA);
      reg_read(8'h50, d);    chk("R8 undefined read", 32'(d), 32'h00);
      reg_read(8'h42, d);    chk("R8 undefined write", 32'(d), 32'h00);
   endtask

   task automatic t_decode();
      logic [7:0] d;
      intx_n = 4'b1110;
      wait_cyc(2);
      for (int c = 0; c < 16; c++) begin
         reg_write(8'h42, 8'(c));
         chk("R4 R5 code on input1", 32'(isa_irq), 32'(exp_irq(4'(c))));
      end
      reg_write(8'h42, 8'h00);
      intx_n = 4'b0111;
      reg_write(8'h43, 8'h30);
      wait_cyc(2);
      chk("R4 input4 high nibble", 32'(isa_irq), 32'(exp_irq(4'd3)));
      reg_read(8'h43, d);    chk("R4 map1 readback", 32'(d), 32'h30);
      intx_n = 4'b1111;
      wait_cyc(2);
      chk("R7 release", 32'(isa_irq), 32'h0);
      reg_write(8'h43, 8'h00);
   endtask

   task automatic t_level();
      reg_write(8'h42, 8'h02);
      intx_n = 4'b1110;
      wait_cyc(1);
      chk("R7 one edge", 32'(isa_irq), 32'h0);
      wait_cyc(1);
      chk("R7 two edges", 32'(isa_irq), 32'(exp_irq(4'd2)));
      wait_cyc(3);
      chk("R7 held", 32'(isa_irq), 32'(exp_irq(4'd2)));
      intx_n = 4'b1111;
      wait_cyc(2);
      chk("R7 deassert", 32'(isa_irq), 32'h0);
   endtask

   task automatic t_edge();
      logic [7:0] d;
      reg_write(8'h44, 8'hF1);
      reg_read(8'h44, d);    chk("R6 sens upper bits", 32'(d), 32'h01);
      intx_n = 4'b1110;
      wait_cyc(2);
      chk("R6 pulse", 32'(isa_irq), 32'(exp_irq(4'd2)));
      wait_cyc(1);
      chk("R6 single pulse", 32'(isa_irq), 32'h0);
      wait_cyc(4);
      chk("R6 held low no pulse", 32'(isa_irq), 32'h0);
      intx_n = 4'b1111;
      wait_cyc(3);
      chk("R6 no pulse on release", 32'(isa_irq), 32'h0);
      reg_write(8'h44, 8'h00);
   endtask

   task automatic t_share();
      reg_write(8'h42, 8'h11);
      intx_n = 4'b1101;
      wait_cyc(2);
      chk("R9 input2 alone", 32'(isa_irq), 32'(exp_irq(4'd1)));
      intx_n = 4'b1111;
      wait_cyc(2);
      reg_write(8'h44, 8'h01);
      intx_n = 4'b1100;
      wait_cyc(2);
      chk("R9 edge and level together", 32'(isa_irq), 32'(exp_irq(4'd1)));
      wait_cyc(1);
      chk("R9 level holds after pulse", 32'(isa_irq), 32'(exp_irq(4'd1)));
      reg_write(8'h03, 8'h00);
      reg_write(8'h42, 8'h22);
      chk("R3 locked write keeps route", 32'(isa_irq), 32'(exp_irq(4'd1)));
      intx_n = 4'b1110;
      wait_cyc(2);
      chk("R9 level released", 32'(isa_irq), 32'h0);
      intx_n = 4'b1111;
      wait_cyc(2);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      t_reset();
      t_access();
      t_lock();
      t_decode();
      t_level();
      t_edge();
      t_share();
      finish_run();
   end

endmodule